// File: doc/BRIEF.md
# JTAG Debug Memory Bridge

This block gives a debugger direct access to system memory through the test access port. It sits behind an existing TAP controller. It receives the decoded 4-bit instruction and the capture, shift and update strobes for the data-register path, all in the TCK domain. For each access it runs one single-beat Wishbone classic cycle in the system clock domain. The bus can reach any word address, peripherals included, and it does not matter whether the processor is held in reset or running.

Three instructions are recognised. The pointer instruction exposes a 29-bit word-address register. The fetch instruction exposes a 64-bit data register that returns memory contents and never writes. The exchange instruction exposes the same data register, and each scan both returns the stored word and replaces it with the word shifted in. After every data access the pointer advances by one word, so a debugger can stream consecutive words without reloading the address. The word that the next capture will present is always fetched ahead of time: once on entry to a data instruction, and again after each data update. A toggle request/acknowledge pair carries each access across the two clock domains. The request fields stay frozen until the acknowledge returns.

Top module: `jwb_bridge`

## Requirements
- R1: Only instruction codes 4'b0101 (pointer), 4'b0110 (fetch) and 4'b0111 (exchange) are acted on. Under any other code, tdo stays 0, no bus cycle starts and the pointer keeps its value.
- R2: Under the pointer instruction, a scan shifts 29 bits LSB first. tdo presents the pointer value held at capture, and update loads the shifted-in value as the new pointer.
- R3: Under the exchange instruction, a 64-bit LSB-first scan returns the word stored at the pointer. Update then writes the shifted-in word to that address and fetches the word at the next address.
- R4: Under the fetch instruction, a scan returns the stored word at the pointer. The shifted-in bits are discarded and no write cycle occurs.
- R5: Every data-register update advances the pointer by one, wrapping from all ones to zero.
- R6: Selecting a data instruction fetches the word at the current pointer, so the first capture already returns it.
- R7: Each bus access is a Wishbone classic single cycle. cyc and stb are raised together and all byte selects are set. Address, write enable and write data are held until ack. In an exchange, the write to address A is followed directly by a read of A+1.
- R8: A TCK-side request is raised only when no earlier request is outstanding. An exchange produces exactly two acknowledged bus cycles, and a fetch produces exactly one.
- R9: After reset the bus is idle, the pointer is zero and tdo is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, TCK domain |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| ir | input | 4 | Decoded current instruction from the TAP |
| capture_dr | input | 1 | TAP capture-DR strobe |
| shift_dr | input | 1 | TAP shift-DR strobe |
| update_dr | input | 1 | TAP update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out of the selected register |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 29 | Bus word address |
| wb_sel | output | 8 | Byte selects |
| wb_dat_w | output | 64 | Write data |
| wb_dat_r | input | 64 | Read data |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
The bench streams two exchange scans and then rereads the same words with fetch scans. A design that forgot the prefetch would return the stale word on the first scan, and one that wrote in fetch mode would corrupt memory and raise the write count. The pointer is loaded with all ones before an exchange. A design that did not wrap, or that truncated the address, would show a wrong bus address or a nonzero pointer readback. An unrecognised instruction is also scanned. A design that decoded loosely would drive tdo, start bus cycles or move the pointer.

// File: rtl/jwb_pkg.sv
package jwb_pkg;
    localparam int unsigned IR_W = 4;
    typedef logic [IR_W-1:0] ir_t;

    localparam ir_t IR_POINTER  = 4'b0101;
    localparam ir_t IR_FETCH    = 4'b0110;
    localparam ir_t IR_EXCHANGE = 4'b0111;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_e;

    // Description of one pending access, as seen by the system side.
    typedef struct packed {
        logic do_write;
        logic toggle;
    } req_flags_t;

    function automatic logic is_data_ir(ir_t code);
        return (code == IR_FETCH) || (code == IR_EXCHANGE);
    endfunction
endpackage

// File: rtl/jwb_sync.sv
module jwb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/jwb_tck_regs.sv
module jwb_tck_regs
    import jwb_pkg::*;
#(
    parameter int unsigned AW = 29,
    parameter int unsigned DW = 64
) (
    input  logic          tck,
    input  logic          tck_rst,
    input  ir_t           ir,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    input  logic          ack_s,
    input  logic [DW-1:0] rdata_hold,
    output req_flags_t    req,
    output logic [AW-1:0] req_wadr,
    output logic [AW-1:0] req_radr,
    output logic [DW-1:0] req_wdat,
    output logic [AW-1:0] addr_cur,
    output logic          busy
);
    ir_t           ir_q;
    logic [AW-1:0] addr_q, asr_q;
    logic [DW-1:0] dsr_q, rdbuf_q;
    logic          ack_seen_q;
    logic          sel_ptr, sel_data, entry;

    assign sel_ptr  = (ir == IR_POINTER);
    assign sel_data = is_data_ir(ir);
    assign entry    = sel_data && (ir != ir_q);
    assign busy     = req.toggle ^ ack_s;
    assign addr_cur = addr_q;

    always_comb begin
        if (sel_ptr)       tdo = asr_q[0];
        else if (sel_data) tdo = dsr_q[0];
        else               tdo = 1'b0;
    end

    always_ff @(posedge tck) begin
        if (tck_rst) begin
            ir_q       <= '0;
            addr_q     <= '0;
            asr_q      <= '0;
            dsr_q      <= '0;
            rdbuf_q    <= '0;
            ack_seen_q <= 1'b0;
            req        <= '0;
            req_wadr   <= '0;
            req_radr   <= '0;
            req_wdat   <= '0;
        end else begin
            ir_q <= ir;

            // Returned word lands in the read buffer once per acknowledge.
            if (ack_s != ack_seen_q) begin
                ack_seen_q <= ack_s;
                rdbuf_q    <= rdata_hold;
            end

            if (sel_ptr) begin
                if (capture_dr)     asr_q  <= addr_q;
                else if (shift_dr)  asr_q  <= {tdi, asr_q[AW-1:1]};
                else if (update_dr) addr_q <= asr_q;
            end

            if (sel_data) begin
                if (capture_dr)    dsr_q <= rdbuf_q;
                else if (shift_dr) dsr_q <= {tdi, dsr_q[DW-1:1]};
            end

            if (entry && !busy) begin
                req.do_write <= 1'b0;
                req_radr     <= addr_q;
                req.toggle   <= ~req.toggle;
            end else if (sel_data && update_dr && !busy) begin
                req.do_write <= (ir == IR_EXCHANGE);
                req_wadr     <= addr_q;
                req_wdat     <= dsr_q;
                req_radr     <= addr_q + 1'b1;
                addr_q       <= addr_q + 1'b1;
                req.toggle   <= ~req.toggle;
            end
        end
    end
endmodule

// File: rtl/jwb_wb_master.sv
module jwb_wb_master
    import jwb_pkg::*;
#(
    parameter int unsigned AW = 29,
    parameter int unsigned DW = 64,
    localparam int unsigned SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_s,
    input  logic          req_wr,
    input  logic [AW-1:0] req_wadr,
    input  logic [AW-1:0] req_radr,
    input  logic [DW-1:0] req_wdat,
    output logic          ack_tgl,
    output logic [DW-1:0] rdata_hold,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [AW-1:0] wb_adr,
    output logic [SW-1:0] wb_sel,
    output logic [DW-1:0] wb_dat_w,
    input  logic [DW-1:0] wb_dat_r,
    input  logic          wb_ack
);
    bus_state_e state_q;
    logic       req_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= BUS_IDLE;
            req_seen_q <= 1'b0;
            ack_tgl    <= 1'b0;
            rdata_hold <= '0;
        end else begin
            case (state_q)
                BUS_IDLE: begin
                    if (req_s != req_seen_q) begin
                        req_seen_q <= req_s;
                        state_q    <= req_wr ? BUS_WRITE : BUS_READ;
                    end
                end
                BUS_WRITE: begin
                    if (wb_ack) state_q <= BUS_READ;
                end
                BUS_READ: begin
                    if (wb_ack) begin
                        rdata_hold <= wb_dat_r;
                        ack_tgl    <= ~ack_tgl;
                        state_q    <= BUS_IDLE;
                    end
                end
                default: state_q <= BUS_IDLE;
            endcase
        end
    end

    assign wb_cyc   = (state_q != BUS_IDLE);
    assign wb_stb   = wb_cyc;
    assign wb_we    = (state_q == BUS_WRITE);
    assign wb_adr   = (state_q == BUS_WRITE) ? req_wadr : req_radr;
    assign wb_sel   = {SW{1'b1}};
    assign wb_dat_w = req_wdat;
endmodule

// File: rtl/jwb_bridge.sv
module jwb_bridge
    import jwb_pkg::*;
#(
    parameter int unsigned AW          = 29,
    parameter int unsigned DW          = 64,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SW         = DW / 8
) (
    input  logic          tck,
    input  logic          tck_rst,
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    ir,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    output logic          wb_cyc,
    output logic          wb_stb,
    output logic          wb_we,
    output logic [AW-1:0] wb_adr,
    output logic [SW-1:0] wb_sel,
    output logic [DW-1:0] wb_dat_w,
    input  logic [DW-1:0] wb_dat_r,
    input  logic          wb_ack
);
    req_flags_t    req;
    logic [AW-1:0] req_wadr, req_radr, addr_cur;
    logic [DW-1:0] req_wdat, rdata_hold;
    logic          ack_tgl, ack_s, req_s, busy;

    jwb_tck_regs #(.AW(AW), .DW(DW)) tck_regs_i (
        .tck(tck), .tck_rst(tck_rst), .ir(ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .ack_s(ack_s), .rdata_hold(rdata_hold),
        .req(req), .req_wadr(req_wadr), .req_radr(req_radr), .req_wdat(req_wdat),
        .addr_cur(addr_cur), .busy(busy)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk(clk), .rst(rst), .d(req.toggle), .q(req_s)
    );

    jwb_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk(tck), .rst(tck_rst), .d(ack_tgl), .q(ack_s)
    );

    jwb_wb_master #(.AW(AW), .DW(DW)) wb_master_i (
        .clk(clk), .rst(rst), .req_s(req_s), .req_wr(req.do_write),
        .req_wadr(req_wadr), .req_radr(req_radr), .req_wdat(req_wdat),
        .ack_tgl(ack_tgl), .rdata_hold(rdata_hold),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
    );
endmodule

// File: rtl/jwb_bridge_chk.sv
module jwb_bridge_chk
    import jwb_pkg::*;
#(
    parameter int unsigned AW = 29,
    parameter int unsigned DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          tck,
    input logic          tck_rst,
    input logic [3:0]    ir,
    input logic          update_dr,
    input logic          wb_cyc,
    input logic          wb_we,
    input logic          wb_ack,
    input logic [AW-1:0] wb_adr,
    input logic [DW-1:0] wb_dat_w,
    input logic [AW-1:0] addr_cur,
    input logic          busy,
    input logic          req_toggle
);
    // R7
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_w)));

    // R3
    write_then_next_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && wb_we && wb_ack) |=> (wb_cyc && !wb_we && (wb_adr == $past(wb_adr) + 1'b1)));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !wb_cyc);

    // R5
    pointer_advance_chk: assert property (@(posedge tck) disable iff (tck_rst)
        (update_dr && is_data_ir(ir) && !busy) |=> (addr_cur == $past(addr_cur) + 1'b1));

    // R8
    one_outstanding_chk: assert property (@(posedge tck) disable iff (tck_rst)
        busy |=> (req_toggle == $past(req_toggle)));
endmodule

bind jwb_bridge jwb_bridge_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst(rst), .tck(tck), .tck_rst(tck_rst), .ir(ir),
    .update_dr(update_dr), .wb_cyc(wb_cyc), .wb_we(wb_we), .wb_ack(wb_ack),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .addr_cur(addr_cur),
    .busy(busy), .req_toggle(req.toggle)
);

// File: tb/jwb_bridge_tb_top.sv
`timescale 1ns/1ps
module jwb_bridge_tb_top;
    localparam int AW = 29;
    localparam int DW = 64;

    logic clk = 1'b0, rst = 1'b1, tck = 1'b0, tck_rst = 1'b1;
    logic [3:0] ir = 4'b1111;
    logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
    logic tdo, wb_cyc, wb_stb, wb_we, wb_ack;
    logic [AW-1:0] wb_adr;
    logic [7:0] wb_sel;
    logic [DW-1:0] wb_dat_w, wb_dat_r;

    int checks = 0, errors = 0;
    int ack_count = 0, write_count = 0, bad_sel = 0;
    logic [AW-1:0] last_wadr, last_radr;
    logic [DW-1:0] mem [16];

    always #4 clk = ~clk;

    jwb_bridge dut_i (
        .tck(tck), .tck_rst(tck_rst), .clk(clk), .rst(rst), .ir(ir),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .tdi(tdi), .tdo(tdo), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
        .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w),
        .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
    );

    function automatic logic [DW-1:0] seed(int k);
        return {8'hA0 + 8'(k), 24'h3C5A96, 32'hFEED0000 + 32'(k * 7)};
    endfunction

    // Memory model: one-cycle registered ack, word index from low address bits.
    assign wb_dat_r = mem[wb_adr[3:0]];
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) mem[k] <= seed(k);
            wb_ack <= 1'b0;
        end else begin
            wb_ack <= wb_cyc && wb_stb && !wb_ack;
            if (wb_cyc && wb_stb && !wb_ack) begin
                if (wb_sel != 8'hFF) bad_sel <= bad_sel + 1;
                if (wb_we) begin
                    mem[wb_adr[3:0]] <= wb_dat_w;
                    write_count <= write_count + 1;
                    last_wadr <= wb_adr;
                end else begin
                    last_radr <= wb_adr;
                end
            end
            if (wb_ack) ack_count <= ack_count + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tck_cycle();
        #16 tck = 1'b1;
        #32 tck = 1'b0;
        #16;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tck_cycle();
    endtask

    task automatic set_ir(input logic [3:0] code);
        ir = code;
        idle(24);
    endtask

    task automatic scan(input int len, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        capture_dr = 1; tck_cycle(); capture_dr = 0;
        shift_dr = 1;
        for (int i = 0; i < len; i++) begin
            tdi = din[i];
            #1 dout[i] = tdo;
            tck_cycle();
        end
        shift_dr = 0; tdi = 0;
        update_dr = 1; tck_cycle(); update_dr = 0;
        idle(20);
    endtask

    task automatic t_reset();
        check(wb_cyc == 1'b0, "R9 bus idle", 64'(wb_cyc), 0);
        check(tdo == 1'b0, "R9 tdo low", 64'(tdo), 0);
    endtask

    task automatic t_pointer();
        logic [63:0] o;
        set_ir(4'b0101);
        scan(AW, 64'd3, o);
        check(o[AW-1:0] == 0, "R2 R9 first pointer readback", o, 0);
        scan(AW, 64'd5, o);
        check(o[AW-1:0] == 3, "R2 old pointer shifted out", o, 3);
    endtask

    task automatic t_exchange(input logic [63:0] x, input logic [63:0] y);
        logic [63:0] o;
        int a0;
        set_ir(4'b0111);
        check(last_radr == 5, "R6 prefetch address", 64'(last_radr), 5);
        a0 = ack_count;
        scan(DW, x, o);
        check(o == seed(5), "R6 R3 first exchange returns word", o, seed(5));
        check(mem[5] == x, "R3 word written", mem[5], x);
        check(ack_count - a0 == 2, "R8 R7 two bus cycles per exchange", 64'(ack_count - a0), 2);
        scan(DW, y, o);
        check(o == seed(6), "R5 streamed next word", o, seed(6));
        check(mem[6] == y, "R3 second word written", mem[6], y);
        set_ir(4'b0101);
        scan(AW, 64'd5, o);
        check(o[AW-1:0] == 7, "R5 pointer advanced twice", o, 7);
    endtask

    task automatic t_fetch(input logic [63:0] x, input logic [63:0] y);
        logic [63:0] o;
        int w0, a0;
        w0 = write_count;
        set_ir(4'b0110);
        a0 = ack_count;
        scan(DW, 64'hDEAD_BEEF_0BAD_F00D, o);
        check(o == x, "R4 fetch returns word", o, x);
        check(ack_count - a0 == 1, "R8 one bus cycle per fetch", 64'(ack_count - a0), 1);
        scan(DW, 64'h1111_2222_3333_4444, o);
        check(o == y, "R4 R5 fetch streams", o, y);
        check(write_count == w0, "R4 no write in fetch", 64'(write_count), 64'(w0));
        check(mem[5] == x, "R4 memory untouched", mem[5], x);
    endtask

    task automatic t_wrap(input logic [63:0] z);
        logic [63:0] o;
        set_ir(4'b0101);
        scan(AW, 64'h1FFF_FFFF, o);
        check(o[AW-1:0] == 7, "R2 readback before wrap", o, 7);
        set_ir(4'b0111);
        check(last_radr == 29'h1FFF_FFFF, "R7 full-range address", 64'(last_radr), 64'h1FFF_FFFF);
        scan(DW, z, o);
        check(o == seed(15), "R3 word at top address", o, seed(15));
        check(last_wadr == 29'h1FFF_FFFF, "R7 write at top address", 64'(last_wadr), 64'h1FFF_FFFF);
        check(last_radr == 0, "R5 R7 next read wraps", 64'(last_radr), 0);
        set_ir(4'b0101);
        scan(AW, 64'd2, o);
        check(o[AW-1:0] == 0, "R5 pointer wrapped to zero", o, 0);
    endtask

    task automatic t_other_ir();
        logic [63:0] o;
        int a0;
        a0 = ack_count;
        set_ir(4'b0011);
        scan(DW, 64'hFFFF_FFFF_FFFF_FFFF, o);
        check(o == 0, "R1 tdo silent", o, 0);
        check(ack_count == a0, "R1 no bus cycle", 64'(ack_count), 64'(a0));
        set_ir(4'b0101);
        check(ack_count == a0, "R1 pointer instruction no bus cycle", 64'(ack_count), 64'(a0));
        scan(AW, 64'd0, o);
        check(o[AW-1:0] == 2, "R1 pointer unchanged", o, 2);
        check(bad_sel == 0, "R7 all byte selects", 64'(bad_sel), 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst = 0; tck_rst = 0;
        idle(2);
        t_reset();
        t_pointer();
        t_exchange(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        t_fetch(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        t_wrap(64'h5555_AAAA_5555_AAAA);
        t_other_ir();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule